// File: doc/BRIEF.md
# Multiplexed LCD Column Data Sequencer

This block scans a 32-row by 40-column display store one row at a time. For each row it presents that row's 40 on/off column bits together with the index of the row being driven. The store itself sits outside the block. The sequencer drives a row address into it and takes the 40-bit word that comes back combinationally. That word is registered together with the row index. An external row-step enable advances the scan. A sync pulse pulls the row index back to zero, which keeps the block aligned with a row driver and with other column devices in a cascade.

A two-bit multiplex code sets how many rows make up one frame: 8, 16, 24 or 32. The store is divided into banks of that many consecutive rows, and a two-bit bank request picks which bank is shown. A new bank request takes effect only at a frame boundary, so a frame never mixes rows from two banks. From reset until the display-enable input is raised, every column output reads as off.

Top module: `lcd_col_seq`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `col_out` is all zero, `row_out` is 0 and `mem_addr` is 0.
- R2: At a rising clock edge where `disp_en` is 0, `col_out` is loaded with all zeros.
- R3: At a rising clock edge where `disp_en` is 1, `col_out` is loaded with the `mem_data` word that was present for the `mem_addr` of the preceding cycle, and `row_out` is loaded with the frame row of that cycle.
- R4: When `step_en` is 1 and `sync_in` is 0, the frame row rises by one at the next clock unless it is the last row of the frame. With both inputs at 0 the frame row holds.
- R5: The frame length N is set by `mux_sel`: code 0 gives 8 rows, 1 gives 16, 2 gives 24 and 3 gives 32. A step taken from row N-1 (or from any higher row) returns the frame row to 0.
- R6: `sync_in` at 1 forces the frame row to 0 at the next clock and takes priority over `step_en`.
- R7: The bank base row is the active bank times N. The active bank is masked to the valid range: both bits are used for N=8, only bit 0 is used for N=16, and the bank is 0 for N=24 and N=32.
- R8: The active bank is loaded from `bank_sel` only at a frame boundary, meaning a sync or a wrapping step. A change of `bank_sel` at any other time leaves `mem_addr` on the old bank.
- R9: `mem_addr` equals the bank base plus the frame row, modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the frame row by one |
| sync_in | input | 1 | Force the frame row to 0 |
| mux_sel | input | 2 | Multiplex code: 0=8, 1=16, 2=24, 3=32 rows |
| bank_sel | input | 2 | Requested display bank |
| disp_en | input | 1 | Show data when 1; blank when 0 |
| mem_addr | output | 5 | Row address into the display store |
| mem_data | input | 40 | Row word returned by the display store |
| col_out | output | 40 | Column on/off bits for the driven row |
| row_out | output | 5 | Frame row index matching `col_out` |

## Verification
The bench targets four corner cases.

- **Wrap point at every multiplex rate.** A wrong last-row compare would drive a ninth row in 1:8 mode, or never reach row 23 in 1:24 mode.
- **Bank request raised mid-frame.** A design that loaded the bank at once would switch `mem_addr` to the new bank partway through a frame.
- **Out-of-range bank codes in 1:16 and 1:24 modes.** A missing mask would address past the store or show the wrong half.
- **Sync and step in the same cycle, plus blanking before enable.** Wrong priority would leave the row at 1 instead of 0, and missing blanking would let stale data reach the columns.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        MUX_8  = 2'd0,
        MUX_16 = 2'd1,
        MUX_24 = 2'd2,
        MUX_32 = 2'd3
    } mux_code_t;

    // Rows in one frame for a multiplex code; step is a quarter of the store.
    function automatic int unsigned frame_rows(mux_code_t m, int unsigned step);
        return (int'(m) + 1) * step;
    endfunction

    // Bank request restricted to the banks that fit in the store.
    function automatic logic [1:0] bank_keep(mux_code_t m, logic [1:0] b);
        case (m)
            MUX_8:   return b;
            MUX_16:  return {1'b0, b[0]};
            default: return 2'b00;
        endcase
    endfunction

    typedef struct packed {
        logic        boundary;
        logic [4:0]  row;
    } scan_state_t;

endpackage

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
    import lcd_seq_pkg::*;
#(
    parameter int ROWS = 32,
    localparam int RW = $clog2(ROWS),
    localparam int STEP = ROWS / 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic          sync_in,
    input  mux_code_t     mux_code,
    output logic [RW-1:0] row_q,
    output logic          frame_end
);

    logic [RW:0] last_row;
    logic        at_last;

    always_comb begin
        last_row  = (RW+1)'(frame_rows(mux_code, STEP) - 1);
        at_last   = ({1'b0, row_q} >= last_row);
        frame_end = sync_in | (step_en & at_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else if (sync_in) begin
            row_q <= '0;
        end else if (step_en) begin
            row_q <= at_last ? '0 : row_q + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_bank_latch.sv
module lcd_bank_latch
    import lcd_seq_pkg::*;
#(
    parameter int ROWS = 32,
    localparam int RW = $clog2(ROWS),
    localparam int STEP = ROWS / 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_end,
    input  logic [1:0]    bank_req,
    input  mux_code_t     mux_code,
    output logic [1:0]    bank_q,
    output logic [RW-1:0] base_row
);

    logic [1:0] bank_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (frame_end) begin
            bank_q <= bank_req;
        end
    end

    always_comb begin
        bank_eff = bank_keep(mux_code, bank_q);
        base_row = RW'(int'(bank_eff) * int'(frame_rows(mux_code, STEP)));
    end

endmodule

// File: rtl/lcd_col_latch.sv
module lcd_col_latch #(
    parameter int COLS = 40,
    parameter int RW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            show,
    input  logic [COLS-1:0] word_in,
    input  logic [RW-1:0]   row_in,
    output logic [COLS-1:0] col_out,
    output logic [RW-1:0]   row_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            col_out <= '0;
            row_out <= '0;
        end else begin
            col_out <= show ? word_in : '0;
            row_out <= row_in;
        end
    end

endmodule

// File: rtl/lcd_col_seq.sv
module lcd_col_seq
    import lcd_seq_pkg::*;
#(
    parameter int ROWS = 32,
    parameter int COLS = 40,
    localparam int RW = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_en,
    input  logic            sync_in,
    input  logic [1:0]      mux_sel,
    input  logic [1:0]      bank_sel,
    input  logic            disp_en,
    output logic [RW-1:0]   mem_addr,
    input  logic [COLS-1:0] mem_data,
    output logic [COLS-1:0] col_out,
    output logic [RW-1:0]   row_out
);

    mux_code_t     mux_code;
    logic [RW-1:0] scan_row;
    logic          frame_end;
    logic [1:0]    bank_hold;
    logic [RW-1:0] base_row;

    assign mux_code = mux_code_t'(mux_sel);
    assign mem_addr = base_row + scan_row;

    lcd_row_scan #(.ROWS(ROWS)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .sync_in   (sync_in),
        .mux_code  (mux_code),
        .row_q     (scan_row),
        .frame_end (frame_end)
    );

    lcd_bank_latch #(.ROWS(ROWS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .bank_req  (bank_sel),
        .mux_code  (mux_code),
        .bank_q    (bank_hold),
        .base_row  (base_row)
    );

    lcd_col_latch #(.COLS(COLS), .RW(RW)) u_cols (
        .clk     (clk),
        .rst     (rst),
        .show    (disp_en),
        .word_in (mem_data),
        .row_in  (scan_row),
        .col_out (col_out),
        .row_out (row_out)
    );

endmodule

// File: rtl/lcd_col_seq_chk.sv
module lcd_col_seq_chk
    import lcd_seq_pkg::*;
#(
    parameter int ROWS = 32,
    parameter int COLS = 40,
    localparam int RW = $clog2(ROWS),
    localparam int STEP = ROWS / 4
) (
    input logic            clk,
    input logic            rst,
    input logic            step_en,
    input logic            sync_in,
    input logic [1:0]      mux_sel,
    input logic [1:0]      bank_sel,
    input logic            disp_en,
    input logic [COLS-1:0] col_out,
    input logic [RW-1:0]   scan_row,
    input logic [1:0]      bank_hold
);

    logic [RW:0] last_row;
    logic        at_last;

    always_comb begin
        last_row = (RW+1)'(frame_rows(mux_code_t'(mux_sel), STEP) - 1);
        at_last  = ({1'b0, scan_row} >= last_row);
    end

    assert_blank_R2: assert property (@(posedge clk) disable iff (rst)
        !disp_en |=> (col_out == '0));

    assert_row_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !sync_in) |=> $stable(scan_row));

    assert_row_step_R4: assert property (@(posedge clk) disable iff (rst)
        (step_en && !sync_in && !at_last) |=> (scan_row == $past(scan_row) + 1'b1));

    assert_row_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (step_en && !sync_in && at_last) |=> (scan_row == '0));

    assert_sync_zero_R6: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> (scan_row == '0));

    assert_bank_frame_R8: assert property (@(posedge clk) disable iff (rst)
        (!sync_in && !(step_en && at_last)) |=> $stable(bank_hold));

    assert_bank_load_R8: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> (bank_hold == $past(bank_sel)));

endmodule

bind lcd_col_seq lcd_col_seq_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .sync_in   (sync_in),
    .mux_sel   (mux_sel),
    .bank_sel  (bank_sel),
    .disp_en   (disp_en),
    .col_out   (col_out),
    .scan_row  (scan_row),
    .bank_hold (bank_hold)
);

// File: tb/lcd_col_seq_test.sv
module lcd_col_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic        sync_in = 1'b0;
    logic [1:0]  mux_sel = 2'd0;
    logic [1:0]  bank_sel = 2'd0;
    logic        disp_en = 1'b0;
    logic [4:0]  mem_addr;
    logic [39:0] mem_data;
    logic [39:0] col_out;
    logic [4:0]  row_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    int m_row = 0;
    int m_bank = 0;

    always #2 clk = ~clk;

    lcd_col_seq uut (
        .clk      (clk),
        .rst      (rst),
        .step_en  (step_en),
        .sync_in  (sync_in),
        .mux_sel  (mux_sel),
        .bank_sel (bank_sel),
        .disp_en  (disp_en),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .col_out  (col_out),
        .row_out  (row_out)
    );

    function automatic logic [39:0] pat(input logic [4:0] a);
        return {8{a}} ^ 40'hC35A960FE1;
    endfunction

    assign mem_data = pat(mem_addr);

    function automatic int rows_of(input logic [1:0] m);
        return 8 * (int'(m) + 1);
    endfunction

    function automatic int masked(input int b, input logic [1:0] m);
        if (m == 2'd0) return b;
        if (m == 2'd1) return b % 2;
        return 0;
    endfunction

    function automatic logic [4:0] m_addr();
        return 5'((masked(m_bank, mux_sel) * rows_of(mux_sel) + m_row) % 32);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive, predict, advance the model, compare after the edge.
    task automatic cyc(input logic st, input logic sy);
        logic [39:0] exp_col;
        logic [4:0]  exp_row;
        string       rtag;
        string       atag;
        int          n;
        @(negedge clk);
        step_en = st;
        sync_in = sy;
        exp_col = disp_en ? pat(m_addr()) : 40'd0;
        exp_row = 5'(m_row);
        n = rows_of(mux_sel);
        rtag = "R4";
        atag = "R9";
        if (sy) begin
            m_row = 0; m_bank = int'(bank_sel); rtag = "R6"; atag = "R8";
        end else if (st) begin
            if (m_row >= n - 1) begin
                m_row = 0; m_bank = int'(bank_sel); rtag = "R5"; atag = "R8";
            end else begin
                m_row++;
            end
        end
        @(posedge clk);
        #1;
        check(disp_en ? "R3 col_out" : "R2 col_out", 64'(col_out), 64'(exp_col));
        check("R3 row_out", 64'(row_out), 64'(exp_row));
        check({rtag, " ", atag, " mem_addr"}, 64'(mem_addr), 64'(m_addr()));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr = 8'hA7;
        repeat (3) @(posedge clk);
        #1;
        check("R1 col_out in reset", 64'(col_out), 64'd0);
        check("R1 row_out in reset", 64'(row_out), 64'd0);
        check("R1 mem_addr in reset", 64'(mem_addr), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 col_out after reset", 64'(col_out), 64'd0);
        check("R1 mem_addr after reset", 64'(mem_addr), 64'd0);

        // R2: blanked while stepping
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);

        // R3/R5: 1:8 full frames, bank 0
        disp_en = 1'b1;
        for (int i = 0; i < 18; i++) cyc(1'b1, 1'b0);
        // R4: hold
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0);

        // R8: bank change mid-frame, applies at wrap
        bank_sel = 2'd2;
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0);
        check("R8 old bank kept mid-frame", 64'(mem_addr < 5'd8), 64'd1);
        for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0);
        bank_sel = 2'd3;
        cyc(1'b0, 1'b1);
        check("R7 bank 3 base in 1:8", 64'(mem_addr), 64'd24);

        // R7: 1:16 with bank 3 masks to 1
        mux_sel = 2'd1;
        cyc(1'b0, 1'b1);
        check("R7 bank 3 masked in 1:16", 64'(mem_addr), 64'd16);
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0);

        // R5/R7: 1:24, bank forced to 0
        mux_sel = 2'd2;
        cyc(1'b0, 1'b1);
        check("R7 bank 3 forced 0 in 1:24", 64'(mem_addr), 64'd0);
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0);

        // R5: 1:32
        mux_sel = 2'd3;
        cyc(1'b0, 1'b1);
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0);

        // R6: sync and step together
        mux_sel = 2'd0;
        bank_sel = 2'd1;
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b0);
        cyc(1'b1, 1'b0);
        cyc(1'b1, 1'b1);
        check("R6 sync beats step", 64'(mem_addr), 64'd8);

        // R2: blank again after enable dropped
        disp_en = 1'b0;
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0);
        disp_en = 1'b1;

        // mixed pattern across rates and banks
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            bank_sel = lfsr[5:4];
            if (lfsr[7:6] == 2'b11 && lfsr[2]) mux_sel = lfsr[1:0];
            cyc(lfsr[0] | lfsr[3], (lfsr[7:6] == 2'b11));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule